// File: doc/BRIEF.md
# Tristate Ternary DAC Pattern Driver

This block drives a small group of tristate pins that feed an external resistor network acting as a digital-to-analog converter. On every sample tick it advances a waveform source and turns the current sample into pin states. In binary coding every pin is driven low or high. In ternary coding each pin carries one base-3 digit, and the high-impedance state stands for the middle digit. With four pins the external network can then resolve 81 levels instead of 16.

Two active-low pushbuttons change the settings at run time. Each one is synchronized and debounced. One button flips between binary and ternary coding. The other flips between a rising ramp and a sine source. Status outputs report the active coding and the active source, so the surrounding logic can follow the current setting.

Top module: `tdac_driver`

## Requirements
- R1: After reset the coding is ternary (`ternary_o`=1), the source is the ramp (`sine_o`=0), the sample code is 0 and every pin is driven low (`pin_oe`=all ones, `pin_out`=all zeros).
- R2: In ternary coding the sample code is split into base-3 digits, with `pin_oe[NPINS-1]`/`pin_out[NPINS-1]` carrying weight 3^(NPINS-1) and each lower index one third of the weight above it. Digit 0 gives oe=1,out=0. Digit 1 gives oe=0,out=0, which is high impedance. Digit 2 gives oe=1,out=1.
- R3: In binary coding every `pin_oe` bit is 1, and `pin_out` equals the sample code in plain binary, with the most significant bit on index NPINS-1.
- R4: Ternary codes span 0 to 3^NPINS-1 (80 for four pins) and binary codes span 0 to 2^NPINS-1 (15). The top code drives every pin high, and code 0 drives every pin low.
- R5: A tick is taken at one rising edge and changes the sample code. All pin enables and values then move together at the next rising edge.
- R6: Each debounced press of `mode_btn_n` flips the coding. On the same edge the ramp value and the sine index both return to 0.
- R7: Each debounced press of `wave_btn_n` flips the source between ramp and sine. On the same edge the ramp value and the sine index both return to 0.
- R8: In ramp source each tick adds 1 to the code. After the top code of the current coding, the next tick wraps the code to 0.
- R9: In sine source the code for index i (0 to 31, one step per tick, wrapping) is floor((M*(256+s)+256)/512), where M is the top code of the current coding and s is a signed quarter-wave value. For indices 0..7, 8..15, 16..23 and 24..31 with k=i mod 8, s is Q[k], Q[8-k], -Q[k] and -Q[8-k]. Q = 0,50,98,142,181,213,237,251,256.
- R10: A button level must stay low for DEB_CYCLES consecutive cycles after synchronization before it counts as a press. Shorter low pulses have no effect, and holding a button down produces exactly one toggle.
- R11: With no tick and no press, the pins and the sample code hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle pulse that advances the waveform |
| mode_btn_n | input | 1 | Active-low button that flips binary/ternary coding |
| wave_btn_n | input | 1 | Active-low button that flips ramp/sine source |
| pin_oe | output | NPINS | Per-pin output enable (0 = high impedance) |
| pin_out | output | NPINS | Per-pin driven value |
| ternary_o | output | 1 | 1 when ternary coding is active |
| sine_o | output | 1 | 1 when the sine source is active |

## Verification
The assertions assume that `sample_tick` is a single-cycle pulse. They also assume that the coding never changes unless a debounced press arrives, so any check on ramp stepping or wrapping is conditioned on there being no restart in that cycle. The button inputs may bounce freely, because the synchronizer and debounce logic absorb that. The stimulus changes every input only on falling clock edges, holds each real press well beyond the debounce window, and applies deliberately short glitches so that the press filter is exercised.

// File: rtl/tdac_pkg.sv
package tdac_pkg;

    // Integer power of three, used to weight the ternary digits.
    function automatic int pow3(input int e);
        int r;
        r = 1;
        for (int k = 0; k < e; k++) r = r * 3;
        return r;
    endfunction

    // Quarter-wave sine magnitude, scaled so that 256 equals full amplitude.
    function automatic int qwave(input int k);
        case (k)
            0: return 0;
            1: return 50;
            2: return 98;
            3: return 142;
            4: return 181;
            5: return 213;
            6: return 237;
            7: return 251;
            default: return 256;
        endcase
    endfunction

    typedef struct packed {
        logic tern;
        logic sine;
    } cfg_t;

endpackage

// File: rtl/tdac_btn.sv
module tdac_btn #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic press_o
);
    localparam int DW = $clog2(DEB_CYCLES + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          stable;
        logic [DW-1:0] cnt;
        logic          press;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.sync  = {st_q.sync[0], btn_n};
        st_d.press = 1'b0;
        if (st_q.sync[1] != st_q.stable) begin
            if (st_q.cnt == DW'(DEB_CYCLES - 1)) begin
                st_d.stable = st_q.sync[1];
                st_d.cnt    = '0;
                st_d.press  = st_q.stable & ~st_q.sync[1];
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync: 2'b11, stable: 1'b1, cnt: '0, press: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign press_o = st_q.press;

    // R10: a press is a single-cycle pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.press |=> !st_q.press);

    // R10: a press pulse only follows a settled low level
    a_r10_press_low: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.press |-> !st_q.stable);

endmodule

// File: rtl/tdac_wave.sv
module tdac_wave #(
    parameter int NPINS = 4,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          restart,
    input  logic          tern,
    input  logic          sine,
    output logic [CW-1:0] code
);
    import tdac_pkg::*;

    localparam int MAXT  = pow3(NPINS) - 1;
    localparam int MAXB  = (1 << NPINS) - 1;
    localparam int PHW   = 5;

    typedef struct packed {
        logic [CW-1:0]  ramp;
        logic [PHW-1:0] phase;
    } st_t;

    st_t st_q, st_d;
    logic [CW-1:0] maxc;
    logic [CW-1:0] sine_code;

    assign maxc = tern ? CW'(MAXT) : CW'(MAXB);

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.ramp  = '0;
            st_d.phase = '0;
        end else if (tick) begin
            st_d.ramp  = (st_q.ramp >= maxc) ? '0 : st_q.ramp + 1'b1;
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_comb begin
        int k;
        int mag;
        int prod;
        k = int'(st_q.phase[2:0]);
        if (st_q.phase[3]) mag = qwave(8 - k);
        else               mag = qwave(k);
        if (st_q.phase[4]) prod = int'(maxc) * (256 - mag) + 256;
        else               prod = int'(maxc) * (256 + mag) + 256;
        sine_code = CW'(prod / 512);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = sine ? sine_code : st_q.ramp;

    // R8: ramp steps by one on a tick below the top code
    a_r8_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && st_q.ramp < maxc) |=> st_q.ramp == $past(st_q.ramp) + 1'b1);

    // R8: ramp wraps after the top code
    a_r8_ramp_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && st_q.ramp == maxc) |=> st_q.ramp == '0);

    // R11: without tick or restart the state holds
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> ($stable(st_q.ramp) && $stable(st_q.phase)));

    // R4: the sample never leaves the range of the active coding
    a_r4_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        code <= maxc);

endmodule

// File: rtl/tdac_enc.sv
module tdac_enc #(
    parameter int NPINS = 4,
    parameter int CW    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    code,
    input  logic             tern,
    output logic [NPINS-1:0] oe,
    output logic [NPINS-1:0] val
);
    import tdac_pkg::*;

    localparam int MAXT = pow3(NPINS) - 1;

    typedef struct packed {
        logic [NPINS-1:0] oe;
        logic [NPINS-1:0] val;
    } pins_t;

    pins_t pins_q, pins_d;

    always_comb begin
        int rem;
        int w;
        int d;
        pins_d = pins_q;
        rem    = int'(code);
        for (int i = NPINS - 1; i >= 0; i--) begin
            w   = pow3(i);
            d   = rem / w;
            rem = rem - d * w;
            case (d)
                0:       begin pins_d.oe[i] = 1'b1; pins_d.val[i] = 1'b0; end
                1:       begin pins_d.oe[i] = 1'b0; pins_d.val[i] = 1'b0; end
                default: begin pins_d.oe[i] = 1'b1; pins_d.val[i] = 1'b1; end
            endcase
        end
        if (!tern) begin
            pins_d.oe  = '1;
            pins_d.val = code[NPINS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '{oe: '1, val: '0};
        end else begin
            pins_q <= pins_d;
        end
    end

    assign oe  = pins_q.oe;
    assign val = pins_q.val;

    // R3: binary coding never floats a pin
    a_r3_bin_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !tern |=> &pins_q.oe);

    // R4: full-scale ternary code drives every pin high
    a_r4_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
        (tern && code == CW'(MAXT)) |=> (&pins_q.oe && &pins_q.val));

    // R2: ternary code zero drives every pin low
    a_r2_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tern && code == '0) |=> (&pins_q.oe && pins_q.val == '0));

endmodule

// File: rtl/tdac_driver.sv
module tdac_driver #(
    parameter int NPINS      = 4,
    parameter int DEB_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_tick,
    input  logic             mode_btn_n,
    input  logic             wave_btn_n,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_out,
    output logic             ternary_o,
    output logic             sine_o
);
    import tdac_pkg::*;

    localparam int CW = $clog2(pow3(NPINS));

    cfg_t          cfg_q, cfg_d;
    logic          mode_press;
    logic          wave_press;
    logic          restart;
    logic [CW-1:0] code;

    tdac_btn #(.DEB_CYCLES(DEB_CYCLES)) u_mode_btn (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_n   (mode_btn_n),
        .press_o (mode_press)
    );

    tdac_btn #(.DEB_CYCLES(DEB_CYCLES)) u_wave_btn (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_n   (wave_btn_n),
        .press_o (wave_press)
    );

    assign restart = mode_press | wave_press;

    always_comb begin
        cfg_d = cfg_q;
        if (mode_press) cfg_d.tern = ~cfg_q.tern;
        if (wave_press) cfg_d.sine = ~cfg_q.sine;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{tern: 1'b1, sine: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    tdac_wave #(.NPINS(NPINS), .CW(CW)) u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sample_tick),
        .restart (restart),
        .tern    (cfg_q.tern),
        .sine    (cfg_q.sine),
        .code    (code)
    );

    tdac_enc #(.NPINS(NPINS), .CW(CW)) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (code),
        .tern  (cfg_q.tern),
        .oe    (pin_oe),
        .val   (pin_out)
    );

    assign ternary_o = cfg_q.tern;
    assign sine_o    = cfg_q.sine;

    // R6: a mode press flips the coding
    a_r6_mode_flip: assert property (@(posedge clk) disable iff (!rst_n)
        mode_press |=> cfg_q.tern != $past(cfg_q.tern));

    // R7: a wave press flips the source
    a_r7_src_flip: assert property (@(posedge clk) disable iff (!rst_n)
        wave_press |=> cfg_q.sine != $past(cfg_q.sine));

    // R10: without a press the settings hold
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(cfg_q));

endmodule

// File: tb/tdac_driver_tb.sv
module tdac_driver_tb;
    import tdac_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 4;
    localparam int DEB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic mbtn = 1'b1;
    logic wbtn = 1'b1;
    logic [NP-1:0] oe;
    logic [NP-1:0] outv;
    logic tern;
    logic sine;

    int checks = 0;
    int errors = 0;

    // {ticks to apply, expected oe, expected out} walking the ternary ramp
    localparam logic [15:0] VEC [8] = '{
        {8'd1,  4'b1110, 4'b0000},   // 1  = 0001
        {8'd4,  4'b1101, 4'b0001},   // 5  = 0012
        {8'd8,  4'b1000, 4'b0000},   // 13 = 0111
        {8'd27, 4'b0000, 4'b0000},   // 40 = 1111
        {8'd40, 4'b1111, 4'b1111},   // 80 = 2222
        {8'd1,  4'b1111, 4'b0000},   // wrap to 0
        {8'd26, 4'b1111, 4'b0111},   // 26 = 0222
        {8'd28, 4'b1111, 4'b1000}    // 54 = 2000
    };

    always #(CLK_PERIOD / 2) clk = ~clk;

    tdac_driver #(.NPINS(NP), .DEB_CYCLES(DEB)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (tick),
        .mode_btn_n  (mbtn),
        .wave_btn_n  (wbtn),
        .pin_oe      (oe),
        .pin_out     (outv),
        .ternary_o   (tern),
        .sine_o      (sine)
    );

    function automatic logic [7:0] enc(input int c, input bit t);
        logic [3:0] o;
        logic [3:0] v;
        int r;
        int w;
        int d;
        r = c;
        for (int i = 3; i >= 0; i--) begin
            w = pow3(i);
            d = r / w;
            r = r - d * w;
            o[i] = (d != 1);
            v[i] = (d == 2);
        end
        if (!t) begin
            o = 4'b1111;
            v = c[3:0];
        end
        return {o, v};
    endfunction

    function automatic int sine_ref(input int i, input int m);
        int k;
        int s;
        k = i % 8;
        case ((i % 32) / 8)
            0: s = qwave(k);
            1: s = qwave(8 - k);
            2: s = -qwave(k);
            default: s = -qwave(8 - k);
        endcase
        return (m * (256 + s) + 256) / 512;
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic press(input bit which, input int hold);
        @(negedge clk);
        if (which) wbtn = 1'b0; else mbtn = 1'b0;
        repeat (hold) @(negedge clk);
        wbtn = 1'b1;
        mbtn = 1'b1;
        repeat (30) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 pins", {oe, outv}, 8'b1111_0000);
        check("R1 flags", {6'd0, tern, sine}, 8'b0000_0010);

        // R2, R4, R8: ternary ramp vectors
        for (int v = 0; v < 8; v++) begin
            ticks(int'(VEC[v][15:8]));
            check("R2 R4 R8 ramp vector", {oe, outv}, VEC[v][7:0]);
        end

        // R11: idle cycles keep the pins
        repeat (20) @(negedge clk);
        check("R11 hold", {oe, outv}, 8'b1111_1000);

        // R10: a glitch shorter than the debounce window is ignored
        press(1'b0, 3);
        check("R10 glitch flag", {7'd0, tern}, 8'd1);
        check("R10 glitch pins", {oe, outv}, 8'b1111_1000);

        // R6, R3: to binary, ramp restarts at 0
        press(1'b0, 40);
        check("R6 mode flag", {7'd0, tern}, 8'd0);
        check("R6 R3 restart", {oe, outv}, enc(0, 1'b0));

        // R5: pins move one edge after the tick edge
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check("R5 not yet", {oe, outv}, enc(0, 1'b0));
        @(negedge clk);
        check("R5 updated", {oe, outv}, enc(1, 1'b0));

        ticks(10);
        check("R3 binary 11", {oe, outv}, 8'b1111_1011);
        ticks(4);
        check("R4 binary top", {oe, outv}, 8'b1111_1111);
        ticks(1);
        check("R8 binary wrap", {oe, outv}, 8'b1111_0000);

        // R7, R9: sine in binary coding
        press(1'b1, 40);
        check("R7 source flag", {7'd0, sine}, 8'd1);
        check("R9 binary sine 0", {oe, outv}, enc(sine_ref(0, 15), 1'b0));
        ticks(1);
        check("R9 binary sine 1", {oe, outv}, enc(sine_ref(1, 15), 1'b0));

        // R10, R6: long hold gives one toggle, phase restarts
        press(1'b0, 120);
        check("R10 single toggle", {7'd0, tern}, 8'd1);
        check("R6 sine restart", {oe, outv}, enc(sine_ref(0, 80), 1'b1));

        // R9: full ternary sine period plus wrap
        for (int i = 1; i <= 33; i++) begin
            ticks(1);
            check("R9 ternary sine", {oe, outv}, enc(sine_ref(i, 80), 1'b1));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule